// File: doc/BRIEF.md
# Synchronous Burst Read Port

This block is the read side of a burst-capable NOR-style memory as the device sees it. It holds a small internal word array. A read starts when chip select is low and the address strobe is seen low on a valid clock edge. The port then waits a configured number of clocks and delivers one word per valid clock edge. A ready flag (WAIT, high means "data not valid") shows the host when the word on the data bus can be taken.

A clock-enable input stands in for the host stopping the clock. While it is low, nothing in the port moves: not the latency countdown, not the beat position. Raising output enable at the same time releases the bus. When the clock starts again, the burst carries on from the beat where it stopped. This works whether the stop came during the initial latency or in the middle of the data, and it works any number of times.

In array mode the address steps linearly. For lengths of 4, 8 or 16 it wraps inside the aligned window; in continuous mode it runs on without a window. In single mode one word is repeated for the whole access. A finite single access drops its valid indication after its burst length is used up.

Top module: `sync_burst_rd_port`

## Requirements
- R1: When `ce_n` and `adv_n` are both low at a clock edge with `clk_en` high, `addr` is captured as the start address of a new access. This also restarts any access already under way.
- R2: The latency code `cfg_lat` is sampled at the capture edge; values 0 and 1 act as 2. For a latency L, `wait_o` stays 1 until the L-th valid edge, counting the capture edge as the first. After that edge beat 0 is valid with `wait_o` 0.
- R3: In array mode (`cfg_single`=0), the length code `cfg_len` selects 0=4, 1=8 or 2=16 words. Beat k then outputs the word at (start AND NOT (N-1)) OR ((start+k) AND (N-1)), wrapping inside the aligned N-word window.
- R4: In array mode with `cfg_len`=3 (continuous), beat k outputs the word at (start+k) modulo the array size. The access never ends by itself.
- R5: A clock edge with `clk_en` low changes no state. After resume, the data and `wait_o` continue from the same beat. This holds whether the stop falls in the latency or in the data phase.
- R6: Any number of clock stops within one access leave the beat sequence identical to an uninterrupted one, counted in enabled edges only.
- R7: `dq_oe` and `wait_oe` are 1 only while both `ce_n` and `oe_n` are low. `oe_n` has no effect on latency or beat progress.
- R8: In single mode (`cfg_single`=1), every valid beat outputs the word at the start address. With `cfg_len` 0, 1 or 2, `wait_o` is 0 for exactly 4, 8 or 16 enabled edges after the latency and 1 from then on. With `cfg_len`=3 it stays 0.
- R9: After reset, and after any enabled edge with `ce_n` high, there is no access. `wait_o` is 1 until a new capture.
- R10: With `ld_en` high at a clock edge, `ld_data` is written to array word `ld_addr`. Later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Host clock running; low models a halted clock |
| ce_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Start address |
| cfg_lat | input | LW | Initial latency in clocks (2 to 7) |
| cfg_len | input | 2 | Burst length code: 0=4, 1=8, 2=16, 3=continuous |
| cfg_single | input | 1 | 1 selects single-word mode |
| ld_en | input | 1 | Array write strobe |
| ld_addr | input | AW | Array write address |
| ld_data | input | DW | Array write data |
| dq | output | DW | Read data |
| dq_oe | output | 1 | Data bus driven (0 models high impedance) |
| wait_o | output | 1 | 1 while the data on `dq` is not valid |
| wait_oe | output | 1 | WAIT driven (0 models high impedance) |

## Verification
The bench sweeps every latency code 0 to 7, every length code and both modes from three start addresses. The addresses are a window start, a mid-window position and one near the array top, so that window wrap and continuous roll-over over the array top are both exercised. Each access is mixed with four kinds of cycle: halted clock with the bus released, halted clock with the bus driven, running clock with the bus released, and normal cycles. Expected words and WAIT come from the number of enabled edges since capture, so a design that counts halted edges shows up as a shifted sequence. A design that gates progress on output enable also shows up as a shifted sequence. A design that ignores the wrap rule or the single-mode end shows up as wrong words or a wrong WAIT level.

// File: rtl/sync_burst_rd_port.sv
`timescale 1ns/1ps
module sync_burst_rd_port #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] cfg_lat,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_single,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] dq,
  output logic          dq_oe,
  output logic          wait_o,
  output logic          wait_oe
);
  localparam int BW = 5;
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];
  logic          active, done_r, single_r;
  logic [1:0]    len_r;
  logic [LW-1:0] cnt;
  logic [AW-1:0] ptr;
  logic [BW-1:0] beat;

  wire           latch   = clk_en && !ce_n && !adv_n;
  wire [LW-1:0]  lat_eff = (cfg_lat < LW'(2)) ? LW'(2) : cfg_lat;
  wire [BW-1:0]  nbm1    = (BW'(4) << len_r) - BW'(1);
  wire [AW-1:0]  mask    = AW'(nbm1);
  wire           cont    = (len_r == 2'd3);
  wire [AW-1:0]  ptr_inc = ptr + AW'(1);
  wire [AW-1:0]  ptr_nx  = cont ? ptr_inc : ((ptr & ~mask) | (ptr_inc & mask));
  wire           valid   = active && (cnt == '0) && !done_r;

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      done_r   <= 1'b0;
      single_r <= 1'b0;
      len_r    <= 2'd0;
      cnt      <= '0;
      ptr      <= '0;
      beat     <= '0;
    end else if (clk_en) begin
      if (ce_n) begin
        active <= 1'b0;
      end else if (!adv_n) begin
        active   <= 1'b1;
        done_r   <= 1'b0;
        single_r <= cfg_single;
        len_r    <= cfg_len;
        cnt      <= lat_eff - LW'(1);
        ptr      <= addr;
        beat     <= '0;
      end else if (active) begin
        if (cnt != '0) begin
          cnt <= cnt - LW'(1);
        end else if (!done_r) begin
          if (single_r) begin
            beat <= beat + BW'(1);
            if (!cont && beat == nbm1) done_r <= 1'b1;
          end else begin
            ptr <= ptr_nx;
          end
        end
      end
    end
  end

  assign dq      = mem[ptr];
  assign dq_oe   = !ce_n && !oe_n;
  assign wait_oe = !ce_n && !oe_n;
  assign wait_o  = !valid;

  assert_suspend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(ptr) && $stable(cnt) && $stable(beat) && $stable(active) && $stable(done_r));

  assert_latency_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && active && !ce_n && adv_n && cnt != '0) |=> cnt == $past(cnt) - LW'(1));

  assert_window_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && valid && !single_r && !cont && !ce_n && adv_n)
      |=> ((ptr & ~mask) == ($past(ptr) & ~$past(mask))) && ptr != $past(ptr));

  assert_single_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && active && single_r && !ce_n && adv_n) |=> $stable(ptr));

  assert_end_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && ce_n) |=> wait_o);
endmodule

// File: tb/sync_burst_rd_port_test.sv
`timescale 1ns/1ps
module sync_burst_rd_port_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int LW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, clk_en, ce_n, adv_n, oe_n, cfg_single, ld_en;
  logic [AW-1:0] addr, ld_addr;
  logic [LW-1:0] cfg_lat;
  logic [1:0]    cfg_len;
  logic [DW-1:0] ld_data, dq;
  logic          dq_oe, wait_o, wait_oe;

  sync_burst_rd_port #(.AW(AW), .DW(DW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ce_n(ce_n), .adv_n(adv_n),
    .oe_n(oe_n), .addr(addr), .cfg_lat(cfg_lat), .cfg_len(cfg_len),
    .cfg_single(cfg_single), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .dq(dq), .dq_oe(dq_oe), .wait_o(wait_o), .wait_oe(wait_oe)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [DW-1:0] model [1 << AW];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_access(input int lat, input int len, input bit sgl, input int a, input int seed);
    int leff, n, t, nsusp;
    leff = (lat < 2) ? 2 : lat;
    n = 4 << len;
    cfg_lat = LW'(lat); cfg_len = 2'(len); cfg_single = sgl;
    clk_en = 1; ce_n = 0; adv_n = 0; oe_n = 0; addr = AW'(a);
    @(posedge clk); #1;
    adv_n = 1;
    t = 0; nsusp = 0;
    for (int i = 0; i < leff + 40; i++) begin
      int p, k, ea;
      bit ev;
      string tg;
      p = (i * 7 + seed) % 6;
      clk_en = (p != 0 && p != 1);
      oe_n = (p == 0 || p == 2);
      #1;
      k = t - (leff - 1);
      ev = (t >= leff - 1) && !(sgl && len != 3 && k >= n);
      if (sgl) ea = a;
      else if (len == 3) ea = (a + k) % (1 << AW);
      else ea = (a & ~(n - 1)) | ((a + k) & (n - 1));
      if (t < leff - 1) tg = "R2";
      else if (sgl) tg = "R8";
      else if (len == 3) tg = "R4";
      else tg = "R3";
      if (k == 0) tg = {"R1 ", tg};
      if (nsusp > 1) tg = {tg, " R6"};
      else if (nsusp == 1) tg = {tg, " R5"};
      if (oe_n) begin
        chk(!dq_oe && !wait_oe, "R7 released", {30'd0, dq_oe, wait_oe}, 32'd0);
      end else begin
        chk(dq_oe && wait_oe, "R7 driven", {30'd0, dq_oe, wait_oe}, 32'd3);
        chk(wait_o == !ev, {tg, " wait"}, {31'd0, wait_o}, {31'd0, !ev});
        if (ev) chk(dq == model[ea], {tg, " data"}, {16'd0, dq}, {16'd0, model[ea]});
      end
      @(posedge clk); #1;
      if (clk_en) t++;
      else nsusp++;
    end
    clk_en = 1; ce_n = 1; oe_n = 0;
    #1;
    chk(!dq_oe && !wait_oe, "R7 deselected", {30'd0, dq_oe, wait_oe}, 32'd0);
    @(posedge clk); #1;
    ce_n = 0; adv_n = 1; oe_n = 0;
    #1;
    chk(wait_o == 1'b1, "R9 after end", {31'd0, wait_o}, 32'd1);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clk_en = 1; ce_n = 1; adv_n = 1; oe_n = 1; addr = '0;
    cfg_lat = 3'd2; cfg_len = 2'd0; cfg_single = 0;
    ld_en = 0; ld_addr = '0; ld_data = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    ce_n = 0; oe_n = 0;
    #1;
    chk(wait_o == 1'b1, "R9 reset", {31'd0, wait_o}, 32'd1);
    ce_n = 1; oe_n = 1;
    for (int i = 0; i < (1 << AW); i++) begin
      model[i] = 16'((i * 257) ^ 16'hA5C3);
      ld_en = 1; ld_addr = AW'(i); ld_data = model[i];
      @(posedge clk); #1;
    end
    ld_en = 0;
    for (int lat = 0; lat < 8; lat++)
      for (int len = 0; len < 4; len++)
        for (int s = 0; s < 2; s++) begin
          run_access(lat, len, s[0], 0, lat + len * 3 + s);
          run_access(lat, len, s[0], 13, lat + len * 3 + s + 1);
          run_access(lat, len, s[0], 62, lat + len * 3 + s + 2);
        end
    // R10: overwrite one word, then read it back
    ld_en = 1; ld_addr = AW'(13); ld_data = 16'h1234; model[13] = 16'h1234;
    @(posedge clk); #1;
    ld_en = 0;
    cfg_lat = 3'd2; cfg_len = 2'd0; cfg_single = 1;
    clk_en = 1; ce_n = 0; adv_n = 0; oe_n = 0; addr = AW'(13);
    @(posedge clk); #1;
    adv_n = 1;
    @(posedge clk); #1;
    chk(dq == 16'h1234 && !wait_o, "R10 reload", {15'd0, wait_o, dq}, 32'h1234);
    run_access(3, 1, 0, 12, 4);
    run_access(2, 0, 1, 13, 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule